// File: doc/BRIEF.md
# Instruction RAM bus-ownership switch

This block holds a 16 KB on-chip program RAM that sits behind two ports: an instruction-fetch port for the CPU and a data port with byte enables. The RAM has a single set of storage banks, so at any time only one of the two ports owns it. An ownership bit in a small control register makes that choice. While the data port owns the RAM, boot code or a DMA engine copies a program into it using half-word transfers. Software then returns ownership to the fetch side and writes the mode register. That write moves the address decoder into internal-ROM mode and selects the bus mode. Only after this step, and only with the bus mode that pairs internal ROM with an external bus, does the RAM window answer instruction fetches.

The RAM window is the upper 16 KB of the internal region, `0x000BC000` to `0x000BFFFF`. The lower part of that region, `0x000B8000` to `0x000BBFFF`, belongs to an instruction-only ROM that is not part of this block. This block never answers accesses there. Storage is organised as 4096 words of 32 bits. Both ports see one cycle of read latency.

Top module: `iram_bus_switch`

## Requirements
- R1: After reset the RAM is owned by the fetch side (`ram_on_dbus` = 0), internal-ROM mode is off (`irom_mode` = 0), `bus_mode` is 00, and `if_valid`, `if_err`, `d_ack` and `d_err` are all 0.
- R2: A register write with `reg_sel` = 0 loads `reg_wdata[0]` into the ownership bit, visible on `ram_on_dbus` one cycle later. A value of 1 gives the RAM to the data port and 0 gives it to the fetch port. Other cycles leave the bit unchanged.
- R3: A register write with `reg_sel` = 1 loads `reg_wdata[1:0]` into `bus_mode` and sets `irom_mode` to 1, both visible one cycle later. `irom_mode` then stays 1 until reset.
- R4: A fetch is granted when all of these hold: the address is word-aligned and inside `0x000BC000`–`0x000BFFFF`, `irom_mode` = 1, `bus_mode` = 01, and the fetch side owns the RAM. A granted fetch gives `if_valid` = 1 one cycle later, with `if_rdata` holding the word at address bits [13:2].
- R5: A fetch inside the RAM window that is not granted gives `if_err` = 1 one cycle later. `if_valid` stays 0 and `if_rdata` is 0. Reasons for refusal are: misaligned address, `irom_mode` still 0, `bus_mode` other than 01, or the data side owning the RAM.
- R6: A fetch outside the RAM window gives neither `if_valid` nor `if_err`. This includes the ROM part `0x000B8000`–`0x000BBFFF`.
- R7: When the data side owns the RAM, an access inside the window is a half-word access if both of these hold:
  - `d_addr[0]` = 0;
  - `d_be` = 0011 when `d_addr[1]` = 0, or 1100 when `d_addr[1]` = 1.
  A half-word access gives `d_ack` = 1 one cycle later. A write updates only the enabled half. A read returns the whole word on `d_rdata`.
- R8: When the data side owns the RAM, any access in the window that is not a half-word access gives `d_err` = 1 one cycle later. It does not give `d_ack`, it does not change the RAM, and `d_rdata` is 0.
- R9: In the following cases a data access gives neither `d_ack` nor `d_err`, and a write in those cases leaves the RAM unchanged:
  - the fetch side owns the RAM;
  - the address is in the ROM part;
  - the address is outside the internal region.
- R10: Accesses are judged against the ownership and mode values held before the clock edge. A register write in the same cycle as a fetch or data access affects only later cycles.
- R11: RAM contents survive changes of ownership and mode. A word loaded through the data port is returned unchanged by a later granted fetch, and data writes remain possible after the mode register has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | 32 | Fetch byte address |
| if_valid | output | 1 | Fetch data valid, one cycle after a granted request |
| if_err | output | 1 | Refused fetch in the RAM window |
| if_rdata | output | 32 | Fetched word, 0 unless `if_valid` |
| d_req | input | 1 | Data access request |
| d_we | input | 1 | Data access is a write |
| d_addr | input | 32 | Data byte address |
| d_be | input | 4 | Data byte enables |
| d_wdata | input | 32 | Data write value |
| d_ack | output | 1 | Data access accepted |
| d_err | output | 1 | Data access rejected for its size or alignment |
| d_rdata | output | 32 | Read word, 0 unless an acknowledged read |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the ownership register, 1 selects the mode register |
| reg_wdata | input | 2 | Register write value |
| ram_on_dbus | output | 1 | Ownership bit, 1 when the data side owns the RAM |
| irom_mode | output | 1 | Decoder is in internal-ROM mode |
| bus_mode | output | 2 | Current bus mode field |

## Verification
Three things can fall into the same cycle: a fetch, a data access and a register write that moves ownership. The random phase drives all three ports at once on most cycles. The directed phase forces two cases:
- an ownership change in the same cycle as a granted fetch;
- an ownership change in the same cycle as an acknowledged data read.

In both cases the access must be decided by the owner that held the RAM before the edge. A reference model in the bench applies the register write only after it has predicted the responses of that cycle. It also predicts that only the owning side ever gets `if_valid` or `d_ack`.

// File: rtl/iram_sw_pkg.sv
package iram_sw_pkg;

   // Bus mode field; only BUSMODE_INT_XBUS makes the RAM window executable.
   typedef enum logic [1:0] {
      BUSMODE_EXT      = 2'b00,
      BUSMODE_INT_XBUS = 2'b01,
      BUSMODE_ALT2     = 2'b10,
      BUSMODE_ALT3     = 2'b11
   } bus_mode_e;

   // Register select encoding on the register write port.
   localparam logic REGSEL_OWNER = 1'b0;
   localparam logic REGSEL_MODE  = 1'b1;

endpackage

// File: rtl/iram_sw_regs.sv
module iram_sw_regs
   import iram_sw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      reg_we,
   input  logic      reg_sel,
   input  logic [1:0] reg_wdata,
   output logic      dbus_own,
   output logic      irom_on,
   output bus_mode_e bus_mode
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbus_own <= 1'b0;
         irom_on  <= 1'b0;
         bus_mode <= BUSMODE_EXT;
      end else if (reg_we) begin
         if (reg_sel == REGSEL_MODE) begin
            bus_mode <= bus_mode_e'(reg_wdata);
            irom_on  <= 1'b1;
         end else begin
            dbus_own <= reg_wdata[0];
         end
      end
   end

   // R2: ownership follows a write to the ownership register, and only that
   p_owner_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == REGSEL_OWNER) |=> (dbus_own == $past(reg_wdata[0])));
   p_owner_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_sel == REGSEL_OWNER) |=> $stable(dbus_own));
   // R3: mode write loads the field and enters internal-ROM mode for good
   p_mode_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == REGSEL_MODE) |=> (irom_on && bus_mode == $past(reg_wdata)));
   p_irom_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irom_on |=> irom_on);

endmodule

// File: rtl/iram_sw_decode.sv
module iram_sw_decode #(
   parameter int ADDR_W = 32,
   parameter int RAM_LOG2 = 14,
   parameter int LANES = 4,
   parameter logic [ADDR_W-1:0] RAM_BASE = 32'h000B_C000,
   localparam int LANE_LOG2 = $clog2(LANES),
   localparam int TAG_W = ADDR_W - RAM_LOG2
) (
   input  logic [TAG_W-1:0]     f_tag,
   input  logic [LANE_LOG2-1:0] f_low,
   input  logic [TAG_W-1:0]     d_tag,
   input  logic [LANE_LOG2-1:0] d_low,
   input  logic [LANES-1:0]     d_be,
   output logic                 f_hit,
   output logic                 f_aligned,
   output logic                 d_hit,
   output logic                 d_half_ok
);

   localparam logic [TAG_W-1:0] BASE_TAG = RAM_BASE[ADDR_W-1:RAM_LOG2];

   logic [LANES-1:0] be_exp;

   // Which lane pair a half-word uses depends on how many lanes a word has.
   if (LANES == 2) begin : g_two_lane
      assign be_exp = 2'b11;
   end else begin : g_multi_lane
      logic [LANE_LOG2-2:0] pair;
      assign pair   = d_low[LANE_LOG2-1:1];
      assign be_exp = {{(LANES-2){1'b0}}, 2'b11} << {pair, 1'b0};
   end

   assign f_hit     = (f_tag == BASE_TAG);
   assign f_aligned = (f_low == '0);
   assign d_hit     = (d_tag == BASE_TAG);
   assign d_half_ok = !d_low[0] && (d_be == be_exp);

   // R8: an accepted data access enables exactly two byte lanes
   always_comb begin
      if (d_half_ok) begin
         p_half_two_lanes_r8: assert ($countones(d_be) == 2);
      end
   end

endmodule

// File: rtl/iram_sw_store.sv
module iram_sw_store #(
   parameter int LANES = 4,
   parameter int WORDS = 4096,
   localparam int IDX_W = $clog2(WORDS),
   localparam int DW = LANES * 8
) (
   input  logic             clk,
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   input  logic [LANES-1:0] we,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);

   // One byte bank per lane; shared address, read-before-write.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] bank [WORDS];
      logic [7:0] bank_q;
      always_ff @(posedge clk) begin
         if (en) begin
            if (we[l]) begin
               bank[idx] <= wdata[8*l +: 8];
            end
            bank_q <= bank[idx];
         end
      end
      assign rdata[8*l +: 8] = bank_q;
   end

endmodule

// File: rtl/iram_bus_switch.sv
module iram_bus_switch
   import iram_sw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES = 4,
   parameter int RAM_LOG2 = 14,
   parameter logic [ADDR_W-1:0] RAM_BASE = 32'h000B_C000,
   localparam int DW = LANES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              if_req,
   input  logic [ADDR_W-1:0] if_addr,
   output logic              if_valid,
   output logic              if_err,
   output logic [DW-1:0]     if_rdata,
   input  logic              d_req,
   input  logic              d_we,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic [LANES-1:0]  d_be,
   input  logic [DW-1:0]     d_wdata,
   output logic              d_ack,
   output logic              d_err,
   output logic [DW-1:0]     d_rdata,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [1:0]        reg_wdata,
   output logic              ram_on_dbus,
   output logic              irom_mode,
   output logic [1:0]        bus_mode
);

   localparam int LANE_LOG2 = $clog2(LANES);
   localparam int IDX_W = RAM_LOG2 - LANE_LOG2;
   localparam int WORDS = 1 << IDX_W;

   // Elaboration-time parameter checks
   if (LANES < 2 || (1 << LANE_LOG2) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two and at least 2");
   end
   if (RAM_LOG2 <= LANE_LOG2 || RAM_LOG2 >= ADDR_W) begin : g_bad_size
      $error("RAM_LOG2 must exceed the lane bits and stay below ADDR_W");
   end
   if (RAM_BASE[RAM_LOG2-1:0] != '0) begin : g_bad_base
      $error("RAM_BASE must be aligned to the RAM size");
   end

   logic      dbus_own;
   logic      irom_on;
   bus_mode_e mode_q;

   iram_sw_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .dbus_own  (dbus_own),
      .irom_on   (irom_on),
      .bus_mode  (mode_q)
   );

   logic f_hit, f_aligned, d_hit, d_half_ok;

   iram_sw_decode #(
      .ADDR_W   (ADDR_W),
      .RAM_LOG2 (RAM_LOG2),
      .LANES    (LANES),
      .RAM_BASE (RAM_BASE)
   ) u_dec (
      .f_tag     (if_addr[ADDR_W-1:RAM_LOG2]),
      .f_low     (if_addr[LANE_LOG2-1:0]),
      .d_tag     (d_addr[ADDR_W-1:RAM_LOG2]),
      .d_low     (d_addr[LANE_LOG2-1:0]),
      .d_be      (d_be),
      .f_hit     (f_hit),
      .f_aligned (f_aligned),
      .d_hit     (d_hit),
      .d_half_ok (d_half_ok)
   );

   // Grant logic uses the register state held before the edge.
   logic fetch_ready, f_grant, f_reject;
   logic d_owned, d_grant, d_reject;

   assign fetch_ready = !dbus_own && irom_on && (mode_q == BUSMODE_INT_XBUS);
   assign f_grant     = if_req && f_hit && f_aligned && fetch_ready;
   assign f_reject    = if_req && f_hit && !(f_aligned && fetch_ready);
   assign d_owned     = d_req && d_hit && dbus_own;
   assign d_grant     = d_owned && d_half_ok;
   assign d_reject    = d_owned && !d_half_ok;

   // Single storage port steered by the owner bit.
   logic             mem_en;
   logic [IDX_W-1:0] mem_idx;
   logic [LANES-1:0] mem_we;
   logic [DW-1:0]    mem_q;

   always_comb begin
      mem_en  = f_grant || d_grant;
      mem_idx = dbus_own ? d_addr[RAM_LOG2-1:LANE_LOG2] : if_addr[RAM_LOG2-1:LANE_LOG2];
      mem_we  = (d_grant && d_we) ? d_be : '0;
   end

   iram_sw_store #(
      .LANES (LANES),
      .WORDS (WORDS)
   ) u_store (
      .clk   (clk),
      .en    (mem_en),
      .idx   (mem_idx),
      .we    (mem_we),
      .wdata (d_wdata),
      .rdata (mem_q)
   );

   logic if_valid_q, if_err_q, d_ack_q, d_err_q, d_rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         if_valid_q <= 1'b0;
         if_err_q   <= 1'b0;
         d_ack_q    <= 1'b0;
         d_err_q    <= 1'b0;
         d_rd_q     <= 1'b0;
      end else begin
         if_valid_q <= f_grant;
         if_err_q   <= f_reject;
         d_ack_q    <= d_grant;
         d_err_q    <= d_reject;
         d_rd_q     <= d_grant && !d_we;
      end
   end

   assign if_valid    = if_valid_q;
   assign if_err      = if_err_q;
   assign if_rdata    = if_valid_q ? mem_q : '0;
   assign d_ack       = d_ack_q;
   assign d_err       = d_err_q;
   assign d_rdata     = d_rd_q ? mem_q : '0;
   assign ram_on_dbus = dbus_own;
   assign irom_mode   = irom_on;
   assign bus_mode    = mode_q;

   // R4: fetch data only when the fetch side owned an executable window
   p_fetch_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      if_valid |-> $past(!dbus_own && irom_on && mode_q == BUSMODE_INT_XBUS));
   // R5: a refused fetch shows no RAM contents and never pairs with valid
   p_fetch_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(if_valid && if_err));
   p_fetch_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
      if_err |-> (if_rdata == '0));
   // R7: data responses only while the data side owned the RAM
   p_data_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (d_ack || d_err) |-> $past(dbus_own));
   // R8: accept and reject are exclusive
   p_data_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(d_ack && d_err));
   // R10: the two sides never both succeed in one cycle
   p_one_user_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(if_valid && d_ack));

endmodule

// File: tb/test_iram_bus_switch.sv
`timescale 1ns/1ps
module test_iram_bus_switch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        if_req = 1'b0;
   logic [31:0] if_addr = '0;
   logic        if_valid, if_err;
   logic [31:0] if_rdata;
   logic        d_req = 1'b0, d_we = 1'b0;
   logic [31:0] d_addr = '0;
   logic [3:0]  d_be = '0;
   logic [31:0] d_wdata = '0;
   logic        d_ack, d_err;
   logic [31:0] d_rdata;
   logic        reg_we = 1'b0, reg_sel = 1'b0;
   logic [1:0]  reg_wdata = '0;
   logic        ram_on_dbus, irom_mode;
   logic [1:0]  bus_mode;

   always #2 clk = ~clk;

   iram_bus_switch i_iram_bus_switch (
      .clk(clk), .rst_n(rst_n),
      .if_req(if_req), .if_addr(if_addr), .if_valid(if_valid), .if_err(if_err), .if_rdata(if_rdata),
      .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_be(d_be), .d_wdata(d_wdata),
      .d_ack(d_ack), .d_err(d_err), .d_rdata(d_rdata),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .ram_on_dbus(ram_on_dbus), .irom_mode(irom_mode), .bus_mode(bus_mode)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // Reference state
   logic        m_sel = 1'b0;
   logic        m_irom = 1'b0;
   logic [1:0]  m_mode = 2'b00;
   logic [31:0] m_mem [0:4095];

   localparam logic [31:0] WIN_LO = 32'h000B_C000;
   localparam logic [31:0] WIN_HI = 32'h000B_FFFF;
   localparam logic [31:0] ROM_LO = 32'h000B_8000;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp, input string note);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h %s", req, what, act, exp, note);
      end
   endtask

   function automatic bit in_win(input logic [31:0] a);
      return (a >= WIN_LO) && (a <= WIN_HI);
   endfunction

   function automatic logic [31:0] word_addr(input int unsigned w);
      return WIN_LO + 32'(w * 4);
   endfunction

   // Random word among the 64 preloaded ones (32 lowest, 32 highest)
   function automatic logic [31:0] pick_word();
      int unsigned r = $urandom % 64;
      return word_addr(r < 32 ? r : 4064 + r - 32);
   endfunction

   task automatic cyc(input logic fq, input logic [31:0] fa,
                      input logic dq, input logic dw, input logic [31:0] da,
                      input logic [3:0] dbe, input logic [31:0] dwd,
                      input logic rw, input logic rs, input logic [1:0] rd,
                      input string note);
      logic f_in, f_ok, d_in, d_ok;
      logic e_iv, e_ie, e_da, e_de;
      logic [31:0] e_ir, e_dr;
      logic [11:0] fi, di;
      string ft, dt;
      @(negedge clk);
      if_req = fq; if_addr = fa;
      d_req = dq; d_we = dw; d_addr = da; d_be = dbe; d_wdata = dwd;
      reg_we = rw; reg_sel = rs; reg_wdata = rd;
      fi   = fa[13:2];
      f_in = fq && in_win(fa);
      f_ok = f_in && (fa[1:0] == 2'b00) && !m_sel && m_irom && (m_mode == 2'b01);
      e_iv = f_ok;
      e_ie = f_in && !f_ok;
      e_ir = f_ok ? m_mem[fi] : 32'h0;
      ft   = !f_in ? "R6" : (f_ok ? "R4" : "R5");
      di   = da[13:2];
      d_in = dq && in_win(da) && m_sel;
      d_ok = d_in && !da[0] && (dbe == (da[1] ? 4'b1100 : 4'b0011));
      e_da = d_ok;
      e_de = d_in && !d_ok;
      e_dr = (d_ok && !dw) ? m_mem[di] : 32'h0;
      dt   = !d_in ? "R9" : (d_ok ? "R7" : "R8");
      if (d_ok && dw) begin
         for (int b = 0; b < 4; b++) begin
            if (dbe[b]) m_mem[di][8*b +: 8] = dwd[8*b +: 8];
         end
      end
      if (rw) begin
         if (rs) begin
            m_mode = rd;
            m_irom = 1'b1;
         end else begin
            m_sel = rd[0];
         end
      end
      @(posedge clk);
      #1;
      chk(if_valid === e_iv, ft, "if_valid", 32'(if_valid), 32'(e_iv), note);
      chk(if_err === e_ie, ft, "if_err", 32'(if_err), 32'(e_ie), note);
      chk(if_rdata === e_ir, ft, "if_rdata", if_rdata, e_ir, note);
      chk(d_ack === e_da, dt, "d_ack", 32'(d_ack), 32'(e_da), note);
      chk(d_err === e_de, dt, "d_err", 32'(d_err), 32'(e_de), note);
      chk(d_rdata === e_dr, dt, "d_rdata", d_rdata, e_dr, note);
      chk(ram_on_dbus === m_sel, "R2", "ram_on_dbus", 32'(ram_on_dbus), 32'(m_sel), note);
      chk(irom_mode === m_irom, "R3", "irom_mode", 32'(irom_mode), 32'(m_irom), note);
      chk(bus_mode === m_mode, "R3", "bus_mode", 32'(bus_mode), 32'(m_mode), note);
   endtask

   // Short forms
   task automatic fetch(input logic [31:0] a, input string note);
      cyc(1, a, 0, 0, 0, 0, 0, 0, 0, 0, note);
   endtask
   task automatic dwrite(input logic [31:0] a, input logic [3:0] be, input logic [31:0] v, input string note);
      cyc(0, 0, 1, 1, a, be, v, 0, 0, 0, note);
   endtask
   task automatic dread(input logic [31:0] a, input logic [3:0] be, input string note);
      cyc(0, 0, 1, 0, a, be, 0, 0, 0, 0, note);
   endtask
   task automatic regw(input logic rs, input logic [1:0] v, input string note);
      cyc(0, 0, 0, 0, 0, 0, 0, 1, rs, v, note);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk(ram_on_dbus === 1'b0, "R1", "ram_on_dbus", 32'(ram_on_dbus), 0, "reset");
      chk(irom_mode === 1'b0, "R1", "irom_mode", 32'(irom_mode), 0, "reset");
      chk(bus_mode === 2'b00, "R1", "bus_mode", 32'(bus_mode), 0, "reset");
      chk({if_valid, if_err, d_ack, d_err} === 4'b0, "R1", "responses",
          32'({if_valid, if_err, d_ack, d_err}), 0, "reset");

      fetch(word_addr(0), "R5 before mode write");
      dwrite(word_addr(0), 4'b0011, 32'h1111_2222, "R9 fetch side owns");
      regw(0, 2'b01, "R2 give RAM to data side");
      // R7: preload the used words with half-word writes
      for (int r = 0; r < 64; r++) begin
         int unsigned w = (r < 32) ? r : 4064 + r - 32;
         dwrite(word_addr(w),     4'b0011, {16'h0, 16'(w * 7 + 3)}, "R7 preload low");
         dwrite(word_addr(w) + 2, 4'b1100, {16'(w ^ 16'hA5A5), 16'h0}, "R7 preload high");
      end
      dread(word_addr(5), 4'b0011, "R7 read back");
      dwrite(word_addr(5) + 1, 4'b0011, 32'hDEAD_BEEF, "R8 odd address");
      dwrite(word_addr(5), 4'b1111, 32'hDEAD_BEEF, "R8 full word");
      dwrite(word_addr(5) + 2, 4'b0011, 32'hDEAD_BEEF, "R8 wrong lanes");
      dread(word_addr(5), 4'b0011, "R8 word unchanged");
      dwrite(ROM_LO + 32'h10, 4'b0011, 32'h5555_5555, "R9 rom part");
      dwrite(32'h0002_0000, 4'b0011, 32'h5555_5555, "R9 outside");
      regw(1, 2'b01, "R3 mode write");
      fetch(word_addr(5), "R5 data side owns");
      dwrite(word_addr(6), 4'b1100, 32'hBEEF_0000, "R11 write after mode");
      // R10: owner change with a read in the same cycle
      cyc(0, 0, 1, 0, word_addr(6), 4'b1100, 0, 1, 0, 2'b00, "R10 read during owner change");
      dread(word_addr(6), 4'b1100, "R9 after owner change");
      fetch(word_addr(6), "R11 fetch loaded word");
      fetch(word_addr(4095), "R4 top word");
      fetch(ROM_LO, "R6 rom part");
      fetch(32'h0001_0000, "R6 outside");
      fetch(word_addr(3) + 2, "R5 misaligned");
      // R10: owner change with a fetch in the same cycle
      cyc(1, word_addr(1), 0, 0, 0, 0, 0, 1, 0, 2'b01, "R10 fetch during owner change");
      fetch(word_addr(1), "R5 after owner change");
      regw(0, 2'b00, "R2 back to fetch side");
      regw(1, 2'b10, "R3 other bus mode");
      fetch(word_addr(2), "R5 bus mode 10");
      regw(1, 2'b01, "R3 restore mode");
      fetch(word_addr(2), "R4 restored");

      // Constrained random: all three ports active together
      for (int i = 0; i < 3000; i++) begin
         logic fq, dq, dw, rw, rs;
         logic [31:0] fa, da, dwd;
         logic [3:0] dbe;
         logic [1:0] rd;
         int unsigned k;
         fq = ($urandom % 4) != 0;
         k = $urandom % 8;
         if (k < 5)       fa = pick_word();
         else if (k == 5) fa = pick_word() + 32'(1 + $urandom % 3);
         else if (k == 6) fa = ROM_LO + 32'(($urandom % 4096) * 4);
         else             fa = 32'h0002_0000 + 32'(($urandom % 256) * 4);
         dq = ($urandom % 3) != 0;
         dw = $urandom % 2;
         da = pick_word();
         dbe = 4'b0011;
         if ($urandom % 2) begin
            da = da + 2;
            dbe = 4'b1100;
         end
         k = $urandom % 10;
         if (k == 0)      dbe = 4'($urandom);
         else if (k == 1) da = da + 1;
         else if (k == 2) da = ROM_LO + 32'(($urandom % 4096) * 4);
         dwd = $urandom;
         rw = ($urandom % 10) == 0;
         rs = $urandom % 2;
         rd = rs ? ((($urandom % 4) == 0) ? 2'($urandom) : 2'b01) : 2'($urandom);
         cyc(fq, fa, dq, dw, da, dbe, dwd, rw, rs, rd, "random");
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule